// File: doc/BRIEF.md
# Accumulator and Hidden Operand Register Stage

This block holds a processor's accumulator together with a second, programmer-invisible register that supplies the first operand of an external arithmetic unit. The hidden operand register can capture the accumulator, capture a value from the shared data bus, or take one of several wired-in constants. These constants are zero, the all-ones-minus-one pattern used for decrement, and the decimal-adjust patterns built from a 6 in either or both halves. Increment and decrement are both done as an add with carry-in set, with zero or the minus-two pattern as the operand.

The accumulator has no path from the bus. It is written only from the arithmetic unit's result. To load a plain bus value, the operand register is cleared, and the unit ORs the bus value with that zero and writes it back. The operand register keeps its value when no load is asked for, so the arithmetic input stays steady while the accumulator is being rewritten. The block reports, for each 4-bit digit of the accumulator, whether that digit is 10 or more. It also offers either the accumulator or the arithmetic result as a bus output, qualified by a drive enable, and raises a flag when more than one operand-load request arrives in the same cycle.

Top module: `acc_operand_stage`

## Requirements
- R1: A synchronous active-high reset clears both the accumulator and the operand register to zero.
- R2: The accumulator takes `alu_res` on the edge where `acc_load` is 1 and otherwise holds its value; `bus_in` never changes it.
- R3: With `tmp_from_acc` set and `tmp_from_bus` clear, the operand register captures the accumulator value of that cycle.
- R4: With `tmp_from_bus` set, the operand register captures `bus_in`.
- R5: A constant load with `tmp_const_en` (and no bus or accumulator load) puts 0x00 in the operand register when `tmp_const_dec` is 0 and 0xFE when it is 1.
- R6: A decimal-adjust load (no other load asserted) writes 6 into the upper digit when `tmp_six_hi` is 1 and 6 into the lower digit when `tmp_six_lo` is 1, clearing a digit whose request is 0, giving 0x60, 0x06 or 0x66.
- R7: When no operand load is requested, the operand register keeps its value, including in cycles where the accumulator is written.
- R8: When several operand loads are requested together, the priority is bus first, then accumulator, then the zero/minus-two constant, then the decimal-adjust constant.
- R9: `load_conflict` is 1 in any cycle where two or more of the four load groups (bus, accumulator, zero/minus-two, decimal-adjust) are requested; both decimal-adjust halves together count as one group.
- R10: `digit_ge10[1]` is 1 exactly when accumulator bits 7:4 are 10 or more, and `digit_ge10[0]` is the same test on bits 3:0.
- R11: `bus_oe` follows `bus_drive_en`; when enabled, `bus_out` is `alu_res` if `out_sel_alu` is 1, else the accumulator; when disabled, `bus_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_res | input | W | Result from the external arithmetic unit |
| acc_load | input | 1 | Write the result into the accumulator |
| bus_in | input | W | Value on the shared data bus |
| tmp_from_bus | input | 1 | Operand register loads from the bus |
| tmp_from_acc | input | 1 | Operand register loads from the accumulator |
| tmp_const_en | input | 1 | Operand register loads zero or minus two |
| tmp_const_dec | input | 1 | Chooses minus two (1) or zero (0) |
| tmp_six_hi | input | 1 | Decimal-adjust load, 6 in the upper digit |
| tmp_six_lo | input | 1 | Decimal-adjust load, 6 in the lower digit |
| out_sel_alu | input | 1 | Bus output source: 1 result, 0 accumulator |
| bus_drive_en | input | 1 | Enables the bus output |
| acc_q | output | W | Accumulator contents |
| tmp_q | output | W | Operand register contents, first arithmetic operand |
| digit_ge10 | output | W/4 | Per-digit flag: accumulator digit is 10 or more |
| bus_out | output | W | Value offered to the data bus |
| bus_oe | output | 1 | Drive enable for bus_out |
| load_conflict | output | 1 | More than one operand load group requested |

## Verification
The bench builds the block at its default width of 8, so every one of the 256 accumulator values can be written through the result path. Each value is then copied into the operand register, offered on the bus from both sources, and tested against both digit thresholds. All sixteen combinations of the four operand-load groups are applied from a known register state, which reaches every priority ordering and every conflict case. The constant and decimal-adjust patterns are checked one by one.

// File: rtl/acc_stage_pkg.sv
package acc_stage_pkg;

    typedef enum logic [2:0] {
        SRC_HOLD,
        SRC_BUS,
        SRC_ACC,
        SRC_ZFE,
        SRC_SIX
    } tmp_src_e;

    typedef struct packed {
        logic from_bus;
        logic from_acc;
        logic zfe;
        logic dec;
        logic six_hi;
        logic six_lo;
    } tmp_ctl_t;

    function automatic tmp_src_e pick_src(input tmp_ctl_t c);
        if (c.from_bus)                return SRC_BUS;
        else if (c.from_acc)           return SRC_ACC;
        else if (c.zfe)                return SRC_ZFE;
        else if (c.six_hi || c.six_lo) return SRC_SIX;
        else                           return SRC_HOLD;
    endfunction

    function automatic logic multi_load(input tmp_ctl_t c);
        logic [3:0] grp;
        grp = {c.from_bus, c.from_acc, c.zfe, c.six_hi | c.six_lo};
        return ($countones(grp) > 1);
    endfunction

endpackage

// File: rtl/acc_tmp_sel.sv
module acc_tmp_sel
    import acc_stage_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  tmp_ctl_t     ctl,
    input  logic [W-1:0] bus_in,
    input  logic [W-1:0] acc_q,
    output logic [W-1:0] tmp_q
);
    localparam int NDIG = W / 4;
    localparam int HALF = NDIG / 2;
    localparam logic [W-1:0] DEC_PAT = {{(W-1){1'b1}}, 1'b0};

    logic [W-1:0] six_pat;
    logic [W-1:0] nxt;
    tmp_src_e     src;

    generate
        for (genvar d = 0; d < NDIG; d++) begin : g_six
            if (d >= HALF) begin : g_hi
                assign six_pat[4*d +: 4] = ctl.six_hi ? 4'h6 : 4'h0;
            end else begin : g_lo
                assign six_pat[4*d +: 4] = ctl.six_lo ? 4'h6 : 4'h0;
            end
        end
    endgenerate

    always_comb begin
        src = pick_src(ctl);
        unique case (src)
            SRC_BUS: nxt = bus_in;
            SRC_ACC: nxt = acc_q;
            SRC_ZFE: nxt = ctl.dec ? DEC_PAT : '0;
            SRC_SIX: nxt = six_pat;
            default: nxt = tmp_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) tmp_q <= '0;
        else     tmp_q <= nxt;
    end
endmodule

// File: rtl/acc_reg.sv
module acc_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] res,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= res;
    end
endmodule

// File: rtl/acc_digit_flags.sv
module acc_digit_flags #(
    parameter int W = 8
) (
    input  logic [W-1:0]   val,
    output logic [W/4-1:0] ge10
);
    localparam int NDIG = W / 4;

    generate
        for (genvar d = 0; d < NDIG; d++) begin : g_dig
            assign ge10[d] = val[4*d+3] & (val[4*d+2] | val[4*d+1]);
        end
    endgenerate
endmodule

// File: rtl/acc_bus_drive.sv
module acc_bus_drive #(
    parameter int W = 8
) (
    input  logic [W-1:0] alu_res,
    input  logic [W-1:0] acc_q,
    input  logic         sel_alu,
    input  logic         en,
    output logic [W-1:0] bus_out,
    output logic         bus_oe
);
    always_comb begin
        bus_oe  = en;
        bus_out = '0;
        if (en) bus_out = sel_alu ? alu_res : acc_q;
    end
endmodule

// File: rtl/acc_operand_stage.sv
module acc_operand_stage
    import acc_stage_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   alu_res,
    input  logic           acc_load,
    input  logic [W-1:0]   bus_in,
    input  logic           tmp_from_bus,
    input  logic           tmp_from_acc,
    input  logic           tmp_const_en,
    input  logic           tmp_const_dec,
    input  logic           tmp_six_hi,
    input  logic           tmp_six_lo,
    input  logic           out_sel_alu,
    input  logic           bus_drive_en,
    output logic [W-1:0]   acc_q,
    output logic [W-1:0]   tmp_q,
    output logic [W/4-1:0] digit_ge10,
    output logic [W-1:0]   bus_out,
    output logic           bus_oe,
    output logic           load_conflict
);
    tmp_ctl_t ctl;

    always_comb begin
        ctl.from_bus = tmp_from_bus;
        ctl.from_acc = tmp_from_acc;
        ctl.zfe      = tmp_const_en;
        ctl.dec      = tmp_const_dec;
        ctl.six_hi   = tmp_six_hi;
        ctl.six_lo   = tmp_six_lo;
        load_conflict = multi_load(ctl);
    end

    acc_reg #(.W(W)) u_acc (
        .clk(clk), .rst(rst), .load(acc_load), .res(alu_res), .q(acc_q)
    );

    acc_tmp_sel #(.W(W)) u_tmp (
        .clk(clk), .rst(rst), .ctl(ctl), .bus_in(bus_in),
        .acc_q(acc_q), .tmp_q(tmp_q)
    );

    acc_digit_flags #(.W(W)) u_flags (
        .val(acc_q), .ge10(digit_ge10)
    );

    acc_bus_drive #(.W(W)) u_drv (
        .alu_res(alu_res), .acc_q(acc_q), .sel_alu(out_sel_alu),
        .en(bus_drive_en), .bus_out(bus_out), .bus_oe(bus_oe)
    );
endmodule

// File: rtl/acc_operand_stage_chk.sv
module acc_operand_stage_chk #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst,
    input logic [W-1:0]   alu_res,
    input logic           acc_load,
    input logic [W-1:0]   bus_in,
    input logic           tmp_from_bus,
    input logic           tmp_from_acc,
    input logic           tmp_const_en,
    input logic           tmp_const_dec,
    input logic           tmp_six_hi,
    input logic           tmp_six_lo,
    input logic           out_sel_alu,
    input logic           bus_drive_en,
    input logic [W-1:0]   acc_q,
    input logic [W-1:0]   tmp_q,
    input logic [W/4-1:0] digit_ge10,
    input logic [W-1:0]   bus_out,
    input logic           bus_oe,
    input logic           load_conflict
);
    logic no_load;
    assign no_load = !tmp_from_bus && !tmp_from_acc && !tmp_const_en
                     && !tmp_six_hi && !tmp_six_lo;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (acc_q == '0 && tmp_q == '0));

    a_r2_acc_load: assert property (@(posedge clk) disable iff (rst)
        acc_load |=> acc_q == $past(alu_res));

    a_r2_acc_hold: assert property (@(posedge clk) disable iff (rst)
        !acc_load |=> $stable(acc_q));

    a_r3_from_acc: assert property (@(posedge clk) disable iff (rst)
        (tmp_from_acc && !tmp_from_bus) |=> tmp_q == $past(acc_q));

    a_r4_from_bus: assert property (@(posedge clk) disable iff (rst)
        tmp_from_bus |=> tmp_q == $past(bus_in));

    a_r5_zero_const: assert property (@(posedge clk) disable iff (rst)
        (tmp_const_en && !tmp_const_dec && !tmp_from_bus && !tmp_from_acc)
        |=> tmp_q == '0);

    a_r7_tmp_hold: assert property (@(posedge clk) disable iff (rst)
        no_load |=> $stable(tmp_q));

    a_r9_conflict: assert property (@(posedge clk) disable iff (rst)
        (tmp_from_bus && tmp_from_acc) |-> load_conflict);

    a_r9_single: assert property (@(posedge clk) disable iff (rst)
        (no_load || (tmp_from_bus && !tmp_from_acc && !tmp_const_en
                     && !tmp_six_hi && !tmp_six_lo)) |-> !load_conflict);

    generate
        for (genvar d = 0; d < W/4; d++) begin : g_dchk
            a_r10_digit: assert property (@(posedge clk) disable iff (rst)
                digit_ge10[d] == (acc_q[4*d +: 4] >= 4'd10));
        end
    endgenerate

    a_r11_oe: assert property (@(posedge clk) disable iff (rst)
        bus_oe == bus_drive_en);

    a_r11_acc_out: assert property (@(posedge clk) disable iff (rst)
        (bus_drive_en && !out_sel_alu) |-> bus_out == acc_q);

    a_r11_idle_out: assert property (@(posedge clk) disable iff (rst)
        !bus_drive_en |-> bus_out == '0);
endmodule

bind acc_operand_stage acc_operand_stage_chk #(.W(W)) u_chk (.*);

// File: tb/acc_operand_stage_bench.sv
module acc_operand_stage_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] alu_res, bus_in;
    logic         acc_load, tmp_from_bus, tmp_from_acc, tmp_const_en;
    logic         tmp_const_dec, tmp_six_hi, tmp_six_lo, out_sel_alu, bus_drive_en;
    logic [W-1:0] acc_q, tmp_q, bus_out;
    logic [1:0]   digit_ge10;
    logic         bus_oe, load_conflict;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    acc_operand_stage #(.W(W)) u_acc_operand_stage (
        .clk(clk), .rst(rst), .alu_res(alu_res), .acc_load(acc_load),
        .bus_in(bus_in), .tmp_from_bus(tmp_from_bus), .tmp_from_acc(tmp_from_acc),
        .tmp_const_en(tmp_const_en), .tmp_const_dec(tmp_const_dec),
        .tmp_six_hi(tmp_six_hi), .tmp_six_lo(tmp_six_lo),
        .out_sel_alu(out_sel_alu), .bus_drive_en(bus_drive_en),
        .acc_q(acc_q), .tmp_q(tmp_q), .digit_ge10(digit_ge10),
        .bus_out(bus_out), .bus_oe(bus_oe), .load_conflict(load_conflict)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        acc_load = 0; tmp_from_bus = 0; tmp_from_acc = 0; tmp_const_en = 0;
        tmp_const_dec = 0; tmp_six_hi = 0; tmp_six_lo = 0;
        out_sel_alu = 0; bus_drive_en = 0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        alu_res = 8'h77; bus_in = 8'h99; rst = 1;
        @(negedge clk);
        acc_load = 1; tmp_from_bus = 1;
        tick(); tick();
        chk("R1 acc reset", acc_q, 0);
        chk("R1 tmp reset", tmp_q, 0);
        idle();
        rst = 0;

        for (int v = 0; v < 256; v++) begin
            idle();
            alu_res = v[7:0]; bus_in = ~v[7:0]; acc_load = 1;
            tick();
            chk("R2 acc load", acc_q, v);
            chk("R10 digit flags", digit_ge10,
                {((v >> 4) >= 10) ? 1'b1 : 1'b0, ((v & 15) >= 10) ? 1'b1 : 1'b0});
            acc_load = 0; bus_drive_en = 1; out_sel_alu = 0; alu_res = v[7:0] ^ 8'h5a;
            #1;
            chk("R11 acc on bus", bus_out, v);
            chk("R11 oe", bus_oe, 1);
            out_sel_alu = 1; #1;
            chk("R11 result on bus", bus_out, (v ^ 8'h5a));
            bus_drive_en = 0; #1;
            chk("R11 idle bus", bus_out, 0);
            chk("R11 oe off", bus_oe, 0);
            out_sel_alu = 0;
            tmp_from_acc = 1;
            tick();
            chk("R3 tmp from acc", tmp_q, v);
            chk("R2 acc holds", acc_q, v);
            tmp_from_acc = 0; tmp_from_bus = 1; bus_in = ~v[7:0];
            tick();
            chk("R4 tmp from bus", tmp_q, (~v) & 8'hff);
            chk("R2 bus ignored by acc", acc_q, v);
            tmp_from_bus = 0; acc_load = 1; alu_res = v[7:0] + 8'd1; bus_in = 8'h00;
            tick();
            chk("R7 tmp holds", tmp_q, (~v) & 8'hff);
            chk("R2 acc rewrite", acc_q, (v + 1) & 8'hff);
        end

        idle();
        tmp_const_en = 1; tmp_const_dec = 0; tick();
        chk("R5 zero const", tmp_q, 8'h00);
        tmp_const_dec = 1; tick();
        chk("R5 minus-two const", tmp_q, 8'hfe);
        idle();
        tmp_six_lo = 1; tick();
        chk("R6 low six", tmp_q, 8'h06);
        tmp_six_lo = 0; tmp_six_hi = 1; tick();
        chk("R6 high six", tmp_q, 8'h60);
        tmp_six_lo = 1; #1;
        chk("R9 both halves one group", load_conflict, 0);
        tick();
        chk("R6 both six", tmp_q, 8'h66);
        idle();

        for (int c = 0; c < 16; c++) begin
            int exp_t;
            idle();
            acc_load = 1; alu_res = 8'h3c; tmp_from_bus = 1; bus_in = 8'h11;
            tick();
            idle();
            tmp_from_bus = c[3]; tmp_from_acc = c[2]; tmp_const_en = c[1];
            tmp_six_hi = c[0]; tmp_const_dec = 1; bus_in = 8'ha5;
            #1;
            chk("R9 conflict flag", load_conflict, ($countones(c[3:0]) > 1) ? 1 : 0);
            if (c[3])      exp_t = 8'ha5;
            else if (c[2]) exp_t = 8'h3c;
            else if (c[1]) exp_t = 8'hfe;
            else if (c[0]) exp_t = 8'h60;
            else           exp_t = 8'h11;
            tick();
            chk("R8 load priority", tmp_q, exp_t);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule